// File: doc/BRIEF.md
# Serial Shift Engine with Configurable Select Strobe

This block moves one 8-bit word in and out over a three-wire synchronous serial link: it drives the serial clock and the outgoing data line, and it samples the incoming data line. A 32-bit control word, written whole, switches the engine on, picks which end of the word goes first, and picks how the select strobe behaves. The strobe is either a pulse of 1 to 16 serial-clock periods sent before the data, or a level that covers the whole data phase.

The engine has three states. With the enable bit clear it sleeps, and its whole register and internal state are held at reset values. Setting the enable bit takes it to a setup state, where it waits for a start request. A start request latches the parallel transmit word and makes the engine active. It then sends the strobe and shifts eight bits. It returns to setup with a one-cycle done pulse and the received word on its output. The serial clock runs at the system clock divided by a fixed power of two. Incoming data is sampled when the serial clock rises, and outgoing data changes when it falls.

Top module: `spi_strobe_engine`

## Requirements
- R1: After reset, reg_rdata, sck, mosi, strobe, done and rx_word are all zero.
- R2: The register fields are: bit 0 enable, bit 1 order (0 = most significant bit first, 1 = least significant bit first), bit 2 pulse mode, bits 7:4 strobe width W. Bit 3 and bits 31:8 ignore writes and read as zero, so writing all ones reads back 0x000000F7.
- R3: A write with bit 0 clear puts the engine to sleep and clears the whole register. In sleep, rx_word reads zero and a start request produces no strobe, no sck edge and no done.
- R4: Register writes made while a transfer is active leave the register unchanged.
- R5: A start request is taken only in setup. A second start during an active transfer does not change its timing or its result.
- R6: In pulse mode, strobe rises on the clock edge that takes the start request and stays high for (W+1)*P system clocks, where P is the serial-clock period. sck stays low while strobe is high, and strobe is low during the data phase.
- R7: With pulse mode clear, strobe is high for exactly the 8*P clocks of the data phase, from the edge that takes the start request until done.
- R8: sck is low outside the data phase. The data phase has 8 periods of P clocks, each low for its first half and high for its second half.
- R9: mosi carries tx_word in the chosen order and changes only on falling sck edges, so it is stable while sck is high.
- R10: miso is sampled on each rising sck edge and assembled in the chosen order. rx_word shows the received word from the cycle in which done is high.
- R11: done is a single-cycle pulse. It comes (W+1+8)*P clocks after the start edge in pulse mode and 8*P clocks after it otherwise, and the engine then accepts a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Full-word write strobe for the control register |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control word, unused bits zero |
| start | input | 1 | Transfer request, taken in setup only |
| tx_word | input | 8 | Word to send, latched with the start request |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| strobe | output | 1 | Select strobe, pulse or level |
| rx_word | output | 8 | Last received word |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume that miso changes only while sck is low, and that register writes and start requests are single-cycle pulses synchronous to clk. The bench models the peripheral to match. It moves miso only after it sees a falling sck, and it drives every control input at the falling system-clock edge, so each input is settled long before the rising edge that samples it. The lock and ignored-start cases are exercised by a write and a start issued inside the strobe window of a running transfer.

// File: rtl/spi_se_pkg.sv
package spi_se_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned ORDER_BIT = 1;
    localparam int unsigned PULSE_BIT = 2;
    localparam int unsigned WID_LSB   = 4;
    localparam int unsigned WID_W     = 4;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_SETUP = 2'd1,
        ST_STRB  = 2'd2,
        ST_SHFT  = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic             en;
        logic             lsb_first;
        logic             pulse;
        logic [WID_W-1:0] width;
    } cfg_t;
endpackage

// File: rtl/spi_se_ctrlreg.sv
module spi_se_ctrlreg
    import spi_se_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             lock,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rdata
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr && !lock) begin
            if (wdata[EN_BIT]) begin
                cfg_d.en        = 1'b1;
                cfg_d.lsb_first = wdata[ORDER_BIT];
                cfg_d.pulse     = wdata[PULSE_BIT];
                cfg_d.width     = wdata[WID_LSB +: WID_W];
            end else begin
                cfg_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata                      = '0;
        rdata[EN_BIT]              = cfg_q.en;
        rdata[ORDER_BIT]           = cfg_q.lsb_first;
        rdata[PULSE_BIT]           = cfg_q.pulse;
        rdata[WID_LSB +: WID_W]    = cfg_q.width;
    end

    assign cfg = cfg_q;

    // R4
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr) |=> $stable(cfg_q));
endmodule

// File: rtl/spi_se_shifter.sv
module spi_se_shifter #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              lsb_first,
    input  logic              shift_out,
    input  logic              sample_in,
    input  logic              miso,
    input  logic              commit,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] rxw;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else begin
            if (load) begin
                d.tx = tx_word;
                d.rx = '0;
            end else if (shift_out) begin
                d.tx = lsb_first ? (q.tx >> 1) : (q.tx << 1);
            end
            if (sample_in) begin
                d.rx = lsb_first ? {miso, q.rx[WORD_W-1:1]}
                                 : {q.rx[WORD_W-2:0], miso};
            end
            if (commit) d.rxw = q.rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mosi    = lsb_first ? q.tx[0] : q.tx[WORD_W-1];
    assign rx_word = q.rxw;

    // R3
    sleep_rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rx_word == '0));
endmodule

// File: rtl/spi_strobe_engine.sv
module spi_strobe_engine
    import spi_se_pkg::*;
#(
    parameter int unsigned HALF_LOG2 = 1,
    parameter int unsigned WORD_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        strobe,
    output logic [WORD_W-1:0] rx_word,
    output logic        done
);
    localparam int unsigned TW   = HALF_LOG2 + 1;
    localparam int unsigned HALF = 2 ** HALF_LOG2;
    localparam int unsigned BCW  = $clog2(WORD_W);

    typedef struct packed {
        eng_state_e       st;
        logic [TW-1:0]    tick;
        logic [WID_W-1:0] slot;
        logic [BCW-1:0]   bitn;
        logic             sck;
        logic             strobe;
        logic             done;
    } eng_t;

    eng_t d, q;
    cfg_t cfg;
    logic busy, load, rise, fall, commit;

    assign busy = (q.st == ST_STRB) || (q.st == ST_SHFT);

    spi_se_ctrlreg i_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .lock  (busy),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        load   = 1'b0;
        commit = 1'b0;
        rise   = (q.st == ST_SHFT) && (q.tick == TW'(HALF - 1));
        fall   = (q.st == ST_SHFT) && (&q.tick);
        unique case (q.st)
            ST_SLEEP: begin
                d = '0;
                if (cfg.en) d.st = ST_SETUP;
            end
            ST_SETUP: begin
                if (!cfg.en) begin
                    d = '0;
                end else if (start) begin
                    load     = 1'b1;
                    d.tick   = '0;
                    d.slot   = '0;
                    d.bitn   = '0;
                    d.strobe = 1'b1;
                    d.st     = cfg.pulse ? ST_STRB : ST_SHFT;
                end
            end
            ST_STRB: begin
                d.tick = q.tick + 1'b1;
                if (&q.tick) begin
                    if (q.slot == cfg.width) begin
                        d.st     = ST_SHFT;
                        d.strobe = 1'b0;
                    end else begin
                        d.slot = q.slot + 1'b1;
                    end
                end
            end
            ST_SHFT: begin
                d.tick = q.tick + 1'b1;
                if (&q.tick) begin
                    d.bitn = q.bitn + 1'b1;
                    if (q.bitn == BCW'(WORD_W - 1)) begin
                        d.st     = ST_SETUP;
                        d.strobe = 1'b0;
                        d.done   = 1'b1;
                        commit   = 1'b1;
                    end
                end
            end
            default: d = '0;
        endcase
        d.sck = (d.st == ST_SHFT) && d.tick[TW-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_se_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q.st == ST_SLEEP),
        .load      (load),
        .tx_word   (tx_word),
        .lsb_first (cfg.lsb_first),
        .shift_out (fall),
        .sample_in (rise),
        .miso      (miso),
        .commit    (commit),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    assign sck    = q.sck;
    assign strobe = q.strobe;
    assign done   = q.done;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    strobe_sck_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && cfg.pulse) |-> !strobe);
    // R3
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> (!strobe && !sck));
    // R8
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_SHFT) |-> !sck);
    // R9
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_SHFT) && ($past(q.st) == ST_SHFT) && !$fell(sck)) |-> $stable(mosi));
endmodule

// File: tb/test_spi_strobe_engine.sv
module test_spi_strobe_engine;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_LOG2  = 1;
    localparam int HALF       = 2 ** HALF_LOG2;
    localparam int PER        = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start = 1'b0;
    logic [7:0]  tx_word = '0;
    logic        miso = 1'b0;
    logic        sck, mosi, strobe, done;
    logic [7:0]  rx_word;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_strobe_engine #(.HALF_LOG2(HALF_LOG2), .WORD_W(8)) i_spi_strobe_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .start(start), .tx_word(tx_word), .miso(miso),
        .sck(sck), .mosi(mosi), .strobe(strobe), .rx_word(rx_word), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rb(input logic [31:0] w);
        return w[0] ? (w & 32'h0000_00F7) : 32'h0;
    endfunction

    task automatic write_reg(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(reg_rdata == 0, "R1", "rdata", reg_rdata, 0);
        chk({sck, mosi, strobe, done} == 0, "R1", "sck/mosi/strobe/done", {sck, mosi, strobe, done}, 0);
        chk(rx_word == 0, "R1", "rx_word", rx_word, 0);
    endtask

    task automatic t_regmap();
        write_reg(32'hFFFF_FFFF);
        chk(reg_rdata == 32'hF7, "R2", "all-ones readback", reg_rdata, 32'hF7);
        write_reg(32'h0000_00F6);
        chk(reg_rdata == 0, "R3", "enable clear wipes register", reg_rdata, 0);
    endtask

    task automatic t_sleep_start();
        int seen = 0;
        write_reg(32'h0);
        @(negedge clk); start = 1'b1; tx_word = 8'hA5;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (strobe || sck || done) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R3", "activity in sleep", seen, 0);
        chk(rx_word == 0, "R3", "rx_word in sleep", rx_word, 0);
    endtask

    // One transfer; poke issues a register write and a second start inside the strobe window.
    task automatic t_xfer(input logic [31:0] cw, input logic [7:0] tx,
                          input logic [7:0] pat, input bit poke);
        bit lsb = cw[1];
        bit pulse = cw[2];
        int w = int'(cw[7:4]);
        int strb_cnt = 0, strb_sck = 0, rises = 0, sck_hi = 0, done_cnt = 0, done_at = 0;
        int k = 0;
        int exp_strb = pulse ? (w + 1) * PER : 8 * PER;
        int exp_done = pulse ? (w + 1 + 8) * PER + 1 : 8 * PER + 1;
        bit prev_sck = 1'b0;
        logic [7:0] cap = '0;
        write_reg(cw);
        chk(reg_rdata == rb(cw), "R2", "config readback", reg_rdata, rb(cw));
        miso = pat[lsb ? 0 : 7];
        @(negedge clk); start = 1'b1; tx_word = tx;
        @(negedge clk); start = 1'b0; tx_word = 8'h00;
        for (int s = 1; s < 400 && done_at == 0; s++) begin
            if (poke && s == 2) begin reg_wr = 1'b1; reg_wdata = 32'h0; start = 1'b1; end
            if (poke && s == 3) begin reg_wr = 1'b0; start = 1'b0; end
            if (strobe) strb_cnt++;
            if (strobe && sck) strb_sck++;
            if (sck) sck_hi++;
            if (sck && !prev_sck) begin
                rises++;
                if (k < 8) cap[lsb ? k : 7 - k] = mosi;
            end
            if (!sck && prev_sck) begin
                k++;
                if (k < 8) miso = pat[lsb ? k : 7 - k];
            end
            if (done) begin
                done_cnt++; done_at = s;
                chk(rx_word == pat, "R10", "rx_word at done", rx_word, pat);
            end
            prev_sck = sck;
            if (done_at == 0) @(negedge clk);
        end
        @(negedge clk);
        if (done) done_cnt++;
        if (pulse) begin
            chk(strb_cnt == exp_strb, "R6", "pulse strobe length", strb_cnt, exp_strb);
            chk(strb_sck == 0, "R6", "strobe overlaps sck", strb_sck, 0);
        end else begin
            chk(strb_cnt == exp_strb, "R7", "level strobe length", strb_cnt, exp_strb);
        end
        chk(rises == 8, "R8", "sck rising edges", rises, 8);
        chk(sck_hi == 8 * HALF, "R8", "sck high cycles", sck_hi, 8 * HALF);
        chk(cap == tx, "R9", "mosi bit sequence", cap, tx);
        chk(done_at == exp_done, "R11", "done timing", done_at, exp_done);
        chk(done_cnt == 1, "R11", "done width", done_cnt, 1);
        chk(!strobe && !sck, "R8", "idle after done", {strobe, sck}, 0);
        if (poke) begin
            chk(reg_rdata == rb(cw), "R4", "write during transfer", reg_rdata, rb(cw));
            chk(done_at == exp_done, "R5", "second start ignored", done_at, exp_done);
        end
    endtask

    task automatic t_sleep_clears_rx();
        chk(rx_word != 0, "R10", "rx_word held in setup", rx_word, 32'h1);
        write_reg(32'h0);
        repeat (3) @(negedge clk);
        chk(rx_word == 0, "R3", "sleep clears rx_word", rx_word, 0);
        chk(reg_rdata == 0, "R3", "sleep register", reg_rdata, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_sleep_start();
        t_xfer(32'h0000_0005, 8'hA5, 8'h3C, 1'b0);
        t_xfer(32'h0000_00F7, 8'h81, 8'hD2, 1'b0);
        t_xfer(32'h0000_0001, 8'h6B, 8'h95, 1'b0);
        t_xfer(32'h0000_0003, 8'h1E, 8'h47, 1'b0);
        t_xfer(32'h0000_0025, 8'hC3, 8'h5A, 1'b1);
        t_sleep_clears_rx();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule